// File: doc/BRIEF.md
# Store Function Unit Sequencer

This block steps one store operation through its life inside a scoreboard-scheduled machine. An accepted issue captures the operation code and a signed immediate offset, sets the unit busy and asks the scoreboard for permission to read registers. Once the read grant arrives, the base operand and the store data are taken in and the unit asks for an address slot. Once the address grant arrives, the effective address (base plus sign-extended offset) and the data to be stored are frozen and the unit asks for a write slot. The write grant ends the operation, drops busy and lets the next issue in.

Each holding register is loaded by exactly one handshake and is never loaded again until the next operation. Every request is a flop that stays high until its own grant is seen and drops on the following edge. The scoreboard's arbitration and the memory access itself live outside this block. The block only presents the frozen opcode, address and data while the write request is up.

Top module: `store_unit_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has all three requests low, `busy_o` low and `opc_o`, `st_addr_o` and `st_data_o` zero.
- R2: With `busy_o` low, `issue_i` high at an edge makes `busy_o` and `req_read_o` high after that edge and loads `opc_o` with `issue_opc_i`.
- R3: `issue_i` while `busy_o` is high has no effect: the opcode, the phase and all requests keep their values.
- R4: `go_read_i` while `req_read_o` is high drops `req_read_o` and raises `req_addr_o` after that edge, and captures `rd_base_i` and `rd_data_i`; later changes of those inputs do not alter the stored address or data.
- R5: `go_addr_i` while `req_addr_o` is high drops `req_addr_o` and raises `req_write_o` after that edge; `st_addr_o` then equals the captured base plus the immediate sign-extended from bit IMM_W-1, modulo 2^ADDR_W, and `st_data_o` equals the captured store data.
- R6: `go_write_i` while `req_write_o` is high drops `req_write_o` and `busy_o` after that edge, and an issue in the following cycle is accepted.
- R7: A grant that does not match the raised request (or any grant while idle) changes no output.
- R8: At most one request is high at a time, `busy_o` is high exactly when one request is high, and a request stays high for as long as its grant is absent.
- R9: `opc_o` holds its value from issue until the next accepted issue; `st_addr_o` and `st_data_o` hold from the address grant until the next address grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for a new store |
| issue_opc_i | input | OPC_W | Operation code delivered with issue |
| issue_imm_i | input | IMM_W | Signed address offset delivered with issue |
| go_read_i | input | 1 | Scoreboard grant for the register read |
| go_addr_i | input | 1 | Scoreboard grant for the address step |
| go_write_i | input | 1 | Scoreboard grant for the write |
| rd_base_i | input | DATA_W | Base register value, valid with the read grant |
| rd_data_i | input | DATA_W | Store data register value, valid with the read grant |
| req_read_o | output | 1 | Request to read source registers |
| req_addr_o | output | 1 | Request for an address slot |
| req_write_o | output | 1 | Request to perform the store |
| busy_o | output | 1 | Unit holds an operation in flight |
| opc_o | output | OPC_W | Captured operation code |
| st_addr_o | output | ADDR_W | Frozen effective address |
| st_data_o | output | DATA_W | Frozen store data |

## Verification
The assertions watch the handshake on every cycle: the one-hot request set tied to busy, each request held until granted, the step from one request to the next after each grant, busy falling on the write grant, and the opcode and address registers staying frozen under ignored issues and outside their grant. The arithmetic of the address, with negative offsets and wrap-around, the capture of the operands at the exact grant cycle, the reset values and the absence of effect of stray grants and blocked issues are shown only by the bench's directed scenarios, which compare against values computed from the requirements.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_WAIT_RD   = 2'd1,
    PH_WAIT_ADDR = 2'd2,
    PH_WAIT_WR   = 2'd3
  } phase_e;

endpackage

// File: rtl/store_seq_ctrl.sv
module store_seq_ctrl
  import store_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   issue_i,
  input  logic   go_read_i,
  input  logic   go_addr_i,
  input  logic   go_write_i,
  output phase_e phase_o,
  output logic   take_issue_o,
  output logic   take_read_o,
  output logic   take_addr_o,
  output logic   req_read_o,
  output logic   req_addr_o,
  output logic   req_write_o,
  output logic   busy_o
);

  phase_e phase_q, phase_d;
  logic   take_write;

  // accepted handshakes: a strobe only counts in its own phase
  always_comb begin
    take_issue_o = (phase_q == PH_IDLE)      && issue_i;
    take_read_o  = (phase_q == PH_WAIT_RD)   && go_read_i;
    take_addr_o  = (phase_q == PH_WAIT_ADDR) && go_addr_i;
    take_write   = (phase_q == PH_WAIT_WR)   && go_write_i;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:      if (take_issue_o) phase_d = PH_WAIT_RD;
      PH_WAIT_RD:   if (take_read_o)  phase_d = PH_WAIT_ADDR;
      PH_WAIT_ADDR: if (take_addr_o)  phase_d = PH_WAIT_WR;
      PH_WAIT_WR:   if (take_write)   phase_d = PH_IDLE;
      default:                        phase_d = PH_IDLE;
    endcase
  end

  // requests and busy are their own flops, loaded from the next phase
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      req_read_o  <= 1'b0;
      req_addr_o  <= 1'b0;
      req_write_o <= 1'b0;
      busy_o      <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      req_read_o  <= (phase_d == PH_WAIT_RD);
      req_addr_o  <= (phase_d == PH_WAIT_ADDR);
      req_write_o <= (phase_d == PH_WAIT_WR);
      busy_o      <= (phase_d != PH_IDLE);
    end
  end

  assign phase_o = phase_q;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_read_o, req_addr_o, req_write_o})); // R8
  AST_BUSY_MATCHES_REQ: assert property (@(posedge clk) disable iff (rst)
    busy_o == (req_read_o || req_addr_o || req_write_o)); // R8
  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    req_read_o && !go_read_i |=> req_read_o); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    req_addr_o && !go_addr_i |=> req_addr_o); // R8
  AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
    req_write_o && !go_write_i |=> req_write_o); // R8
  AST_ISSUE_START: assert property (@(posedge clk) disable iff (rst)
    !busy_o && issue_i |=> req_read_o && busy_o); // R2
  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    req_read_o && go_read_i |=> req_addr_o && !req_read_o); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    req_addr_o && go_addr_i |=> req_write_o && !req_addr_o); // R5
  AST_WR_DONE: assert property (@(posedge clk) disable iff (rst)
    req_write_o && go_write_i |=> !busy_o); // R6
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !issue_i |=> !busy_o); // R7

endmodule

// File: rtl/store_seq_agen.sv
module store_seq_agen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[ADDR_W-1:0];
    end
  endgenerate

  assign addr_o = base_i[ADDR_W-1:0] + imm_ext;

endmodule

// File: rtl/store_seq_hold.sv
module store_seq_hold #(
  parameter int OPC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              issue_i,
  input  logic              take_issue_i,
  input  logic              take_read_i,
  input  logic              take_addr_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic [IMM_W-1:0]  imm_o,
  output logic [DATA_W-1:0] base_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] res_o
);

  logic [DATA_W-1:0] data_q;

  // opcode stage: loaded on issue only
  always_ff @(posedge clk) begin
    if (rst) begin
      opc_o <= '0;
      imm_o <= '0;
    end else if (take_issue_i) begin
      opc_o <= opc_i;
      imm_o <= imm_i;
    end
  end

  // operand stage: loaded on the read grant only
  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      data_q <= '0;
    end else if (take_read_i) begin
      base_o <= base_i;
      data_q <= data_i;
    end
  end

  // address/result stage: loaded on the address grant only
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      res_o  <= '0;
    end else if (take_addr_i) begin
      addr_o <= ea_i;
      res_o  <= data_q;
    end
  end

  AST_OPC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy_i && issue_i |=> $stable(opc_o)); // R3
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !take_addr_i |=> $stable(addr_o) && $stable(res_o)); // R9
  AST_OPC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !take_issue_i |=> $stable(opc_o)); // R9

endmodule

// File: rtl/store_unit_seq.sv
module store_unit_seq
  import store_seq_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [OPC_W-1:0]  issue_opc_i,
  input  logic [IMM_W-1:0]  issue_imm_i,
  input  logic              go_read_i,
  input  logic              go_addr_i,
  input  logic              go_write_i,
  input  logic [DATA_W-1:0] rd_base_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              req_read_o,
  output logic              req_addr_o,
  output logic              req_write_o,
  output logic              busy_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o
);

  phase_e            phase;
  logic              take_issue, take_read, take_addr;
  logic [IMM_W-1:0]  imm_q;
  logic [DATA_W-1:0] base_q;
  logic [ADDR_W-1:0] ea;

  store_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue_i),
    .go_read_i    (go_read_i),
    .go_addr_i    (go_addr_i),
    .go_write_i   (go_write_i),
    .phase_o      (phase),
    .take_issue_o (take_issue),
    .take_read_o  (take_read),
    .take_addr_o  (take_addr),
    .req_read_o   (req_read_o),
    .req_addr_o   (req_addr_o),
    .req_write_o  (req_write_o),
    .busy_o       (busy_o)
  );

  store_seq_agen #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_agen (
    .base_i (base_q),
    .imm_i  (imm_q),
    .addr_o (ea)
  );

  store_seq_hold #(
    .OPC_W  (OPC_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_hold (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (busy_o),
    .issue_i      (issue_i),
    .take_issue_i (take_issue),
    .take_read_i  (take_read),
    .take_addr_i  (take_addr),
    .opc_i        (issue_opc_i),
    .imm_i        (issue_imm_i),
    .base_i       (rd_base_i),
    .data_i       (rd_data_i),
    .ea_i         (ea),
    .imm_o        (imm_q),
    .base_o       (base_q),
    .opc_o        (opc_o),
    .addr_o       (st_addr_o),
    .res_o        (st_data_o)
  );

  AST_PHASE_REQ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT_WR) == req_write_o); // R8

endmodule

// File: tb/test_store_unit_seq.sv
module test_store_unit_seq;

  localparam int OPC_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              issue_i = 1'b0;
  logic [OPC_W-1:0]  issue_opc_i = '0;
  logic [IMM_W-1:0]  issue_imm_i = '0;
  logic              go_read_i = 1'b0;
  logic              go_addr_i = 1'b0;
  logic              go_write_i = 1'b0;
  logic [DATA_W-1:0] rd_base_i = '0;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic              req_read_o, req_addr_o, req_write_o, busy_o;
  logic [OPC_W-1:0]  opc_o;
  logic [ADDR_W-1:0] st_addr_o;
  logic [DATA_W-1:0] st_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  store_unit_seq #(
    .OPC_W (OPC_W), .DATA_W (DATA_W), .ADDR_W (ADDR_W), .IMM_W (IMM_W)
  ) i_store_unit_seq (
    .clk (clk), .rst (rst), .issue_i (issue_i), .issue_opc_i (issue_opc_i),
    .issue_imm_i (issue_imm_i), .go_read_i (go_read_i), .go_addr_i (go_addr_i),
    .go_write_i (go_write_i), .rd_base_i (rd_base_i), .rd_data_i (rd_data_i),
    .req_read_o (req_read_o), .req_addr_o (req_addr_o), .req_write_o (req_write_o),
    .busy_o (busy_o), .opc_o (opc_o), .st_addr_o (st_addr_o), .st_data_o (st_data_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: returns 1 ns after the rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] reqs();
    return {busy_o, req_read_o, req_addr_o, req_write_o};
  endfunction

  function automatic logic [ADDR_W-1:0] ea(input logic [DATA_W-1:0] b, input logic [IMM_W-1:0] m);
    return b[ADDR_W-1:0] + {{(ADDR_W-IMM_W){m[IMM_W-1]}}, m};
  endfunction

  task automatic do_issue(input logic [OPC_W-1:0] o, input logic [IMM_W-1:0] m);
    issue_i = 1'b1; issue_opc_i = o; issue_imm_i = m;
    tick();
    issue_i = 1'b0;
  endtask

  task automatic do_read(input logic [DATA_W-1:0] b, input logic [DATA_W-1:0] d);
    go_read_i = 1'b1; rd_base_i = b; rd_data_i = d;
    tick();
    go_read_i = 1'b0; rd_base_i = ~b; rd_data_i = ~d;
  endtask

  task automatic pulse_addr();
    go_addr_i = 1'b1; tick(); go_addr_i = 1'b0;
  endtask

  task automatic pulse_write();
    go_write_i = 1'b1; tick(); go_write_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R1 reqs/busy", reqs(), 4'b0000);
    chk("R1 opc", opc_o, 0);
    chk("R1 addr", st_addr_o, 0);
    chk("R1 data", st_data_o, 0);
    rst = 1'b0;
    tick();
  endtask

  // full store with a positive offset, stepping through every grant
  task automatic t_full_store();
    do_issue(8'h5A, 12'h010);
    chk("R2 busy+req_read", reqs(), 4'b1100);
    chk("R2 opc", opc_o, 8'h5A);
    do_read(32'h0000_1000, 32'hCAFE_F00D);
    chk("R4 req_addr", reqs(), 4'b1010);
    tick();
    chk("R4 operands held", reqs(), 4'b1010);
    pulse_addr();
    chk("R5 req_write", reqs(), 4'b1001);
    chk("R5 addr", st_addr_o, 32'h0000_1010);
    chk("R4 data captured at grant", st_data_o, 32'hCAFE_F00D);
    pulse_write();
    chk("R6 idle", reqs(), 4'b0000);
    chk("R9 opc held after write", opc_o, 8'h5A);
    chk("R9 addr held after write", st_addr_o, 32'h0000_1010);
  endtask

  // negative offset wraps below zero
  task automatic t_negative_wrap();
    do_issue(8'h11, 12'hFF0);
    do_read(32'h0000_0008, 32'h1234_5678);
    pulse_addr();
    chk("R5 negative wrap", st_addr_o, ea(32'h0000_0008, 12'hFF0));
    chk("R5 wrap value", st_addr_o, 32'hFFFF_FFF8);
    chk("R5 data", st_data_o, 32'h1234_5678);
    pulse_write();
    chk("R6 idle", reqs(), 4'b0000);
  endtask

  // issue while busy leaves opcode and phase alone, in every busy phase
  task automatic t_issue_blocked();
    do_issue(8'hA1, 12'h004);
    do_issue(8'hB2, 12'h7FF);
    chk("R3 phase rd", reqs(), 4'b1100);
    chk("R3 opc rd", opc_o, 8'hA1);
    do_read(32'h100, 32'h77);
    do_issue(8'hC3, 12'h7FF);
    chk("R3 phase addr", reqs(), 4'b1010);
    pulse_addr();
    chk("R3 offset from first issue", st_addr_o, 32'h104);
    issue_i = 1'b1; issue_opc_i = 8'hD4; go_write_i = 1'b1;
    tick();
    issue_i = 1'b0; go_write_i = 1'b0;
    chk("R3 issue with write grant", reqs(), 4'b0000);
    chk("R3 opc kept", opc_o, 8'hA1);
  endtask

  // grants that do not match the raised request
  task automatic t_stray_grants();
    go_read_i = 1'b1; go_addr_i = 1'b1; go_write_i = 1'b1; rd_base_i = 32'h9999;
    tick(); tick();
    go_read_i = 1'b0; go_addr_i = 1'b0; go_write_i = 1'b0;
    chk("R7 idle grants", reqs(), 4'b0000);
    chk("R7 idle addr", st_addr_o, 32'h104);
    do_issue(8'h22, 12'h001);
    go_addr_i = 1'b1; go_write_i = 1'b1;
    tick();
    go_addr_i = 1'b0; go_write_i = 1'b0;
    chk("R7 wrong grants in read", reqs(), 4'b1100);
    do_read(32'h200, 32'h55);
    go_read_i = 1'b1; go_write_i = 1'b1;
    tick();
    go_read_i = 1'b0; go_write_i = 1'b0;
    chk("R7 wrong grants in addr", reqs(), 4'b1010);
    chk("R7 addr untouched", st_addr_o, 32'h104);
    pulse_addr();
    go_read_i = 1'b1; go_addr_i = 1'b1;
    tick();
    go_read_i = 1'b0; go_addr_i = 1'b0;
    chk("R7 wrong grants in write", reqs(), 4'b1001);
    chk("R7 addr", st_addr_o, 32'h201);
    chk("R7 data", st_data_o, 32'h55);
    pulse_write();
  endtask

  // requests are held across long waits; back-to-back issue after write
  task automatic t_hold_and_back_to_back();
    do_issue(8'h33, 12'h000);
    for (int k = 0; k < 5; k++) tick();
    chk("R8 read req held", reqs(), 4'b1100);
    do_read(32'hFFFF_FFFF, 32'h0);
    for (int k = 0; k < 5; k++) tick();
    chk("R8 addr req held", reqs(), 4'b1010);
    pulse_addr();
    for (int k = 0; k < 5; k++) tick();
    chk("R8 write req held", reqs(), 4'b1001);
    pulse_write();
    do_issue(8'h44, 12'h7FF);
    chk("R6 issue right after write", reqs(), 4'b1100);
    chk("R6 new opc", opc_o, 8'h44);
    do_read(32'h8000_0000, 32'hABCD);
    pulse_addr();
    chk("R5 max positive offset", st_addr_o, ea(32'h8000_0000, 12'h7FF));
    pulse_write();
  endtask

  initial begin
    rst = 1'b1;
    t_reset();
    t_full_store();
    t_negative_wrap();
    t_issue_blocked();
    t_stray_grants();
    t_hold_and_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule